// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block keeps the 8-bit status register of a serial NOR flash and rules on every command that writes. A command decoder in front of it presents one decoded command per strobe, together with the target address and, for a status write, the new values of the non-volatile fields. One cycle later the block raises exactly one of two flags, accept or reject, and updates the register. A simulated array timer tells the block through a single-cycle done pulse when a program, erase or status write has finished.

An accepted command is allowed to write only when several conditions hold together. The write enable latch must be set. The device must be idle. The target address must lie outside the range chosen by the block-protect field. A status write must not meet hardware protection, which is the status-write-disable bit combined with a low write-protect pin. A rejected command changes nothing, including the latch. A status read is always accepted. After it, the register is shifted out serially for as long as the read select stays low, and a fresh copy is taken at every byte boundary, so software polling the busy bit sees it clear.

Top module: `sfp_status_ctrl`

## Requirements
- R1: After reset the busy and latch bits are 0, the non-volatile fields hold the INIT_NV parameter (default all zero), both flags are 0 and the serial output is 0.
- R2: The status byte is laid out as bit 7 status-write-disable, bit 6 quad enable, bits 5..2 protect level (bit 5 most significant), bit 1 write enable latch, bit 0 busy. An accepted status write loads bits 7..2 from nv_wdata[5:0] in that order.
- R3: Status write (code 2), page program (3), sector erase (4), block erase (5) and chip erase (6) are rejected when the latch is 0.
- R4: Protect level 0 protects nothing, level 15 everything, and level N from 1 to 14 the top 2^(N-1) 64 KiB blocks (all of them once that reaches the block count). A program or erase at a protected address is rejected and leaves the latch as it was.
- R5: Write enable (code 0) sets the latch and write disable (code 1) clears it. The done pulse while busy clears both busy and latch. A done pulse while idle changes nothing.
- R6: An accepted write-type command sets busy until the done pulse. While busy, every command except status read is rejected.
- R7: Chip erase is accepted only when the protect level is 0.
- R8: With status-write-disable at 1, quad enable at 0 and wp_n low, a status write is rejected and bits 7..2 stay unchanged. Programs outside the protected range are still accepted.
- R9: sio2_is_data equals quad enable. While quad enable is 1, the wp_n level does not engage hardware protection.
- R10: Status read (code 7) is always accepted, including while busy. While rd_sel_n stays low, each rd_shift strobe puts the next status bit on so_bit, most significant first, one cycle later, and the byte repeats without end.
- R11: The register is sampled at the first strobe of each byte. A change in the middle of a byte appears only in the next byte.
- R12: Each command strobe gives exactly one of cmd_ok and cmd_rej, one cycle after the strobe and for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | One-cycle decoded command strobe |
| cmd_op | input | 3 | Command code (0 wren, 1 wrdi, 2 wrsr, 3 pp, 4 se, 5 be, 6 ce, 7 rdsr) |
| cmd_addr | input | ADDR_W | Target byte address of program or erase |
| nv_wdata | input | 6 | New values for status bits 7..2 |
| wp_n | input | 1 | Write-protect pin level, active low |
| done_pulse | input | 1 | Array operation finished |
| rd_sel_n | input | 1 | Serial read select, active low |
| rd_shift | input | 1 | One-cycle strobe per serial clock falling edge |
| cmd_ok | output | 1 | Command accepted |
| cmd_rej | output | 1 | Command rejected |
| status_o | output | 8 | Current status register |
| so_bit | output | 1 | Serial status output bit |
| sio2_is_data | output | 1 | Shared pin serves as data line 2 |

## Verification
The assertions assume the done pulse comes only from an operation this block started. They also assume that a status read and a shift strobe never share a cycle, and that strobes arrive only while the read select is low. The stimulus keeps to these assumptions. Each command and each shift strobe is a single-cycle pulse issued from a task that waits a full cycle before the next one. The done pulse is raised only after an accepted write-type command, except once, deliberately, while the device is idle. The read select is lowered before the status read and raised only after the last shift.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [2:0] {
        OP_WREN = 3'd0,
        OP_WRDI = 3'd1,
        OP_WRSR = 3'd2,
        OP_PP   = 3'd3,
        OP_SE   = 3'd4,
        OP_BE   = 3'd5,
        OP_CE   = 3'd6,
        OP_RDSR = 3'd7
    } sfp_op_e;

    typedef struct packed {
        logic       srwd;
        logic       qe;
        logic [3:0] bp;
        logic       wel;
        logic       wip;
    } sfp_status_t;

    typedef struct packed {
        logic ok;
        logic set_wel;
        logic clr_wel;
        logic start;
        logic load_nv;
    } sfp_decision_t;

    localparam int unsigned SFP_STATUS_W = 8;
    localparam int unsigned SFP_NV_W     = 6;
    localparam logic [3:0]  SFP_BP_ALL   = 4'hF;

    function automatic logic sfp_is_array_op(sfp_op_e op);
        return (op == OP_PP) || (op == OP_SE) || (op == OP_BE);
    endfunction

endpackage

// File: rtl/sfp_protect_chk.sv
module sfp_protect_chk #(
    parameter int unsigned ADDR_W  = 21,
    parameter int unsigned BLOCK_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        bp,
    output logic              hit
);
    localparam int unsigned BLK_W = ADDR_W - BLOCK_W;
    localparam int unsigned NBLK  = 1 << BLK_W;

    int unsigned         span_log;
    int unsigned         lo_blk;
    logic [ADDR_W:0]     lo_addr;

    always_comb begin
        span_log = 0;
        lo_blk   = 0;
        lo_addr  = '0;
        hit      = 1'b0;
        if (bp == sfp_pkg::SFP_BP_ALL) begin
            hit = 1'b1;
        end else if (bp != 4'd0) begin
            span_log = 32'(bp) - 1;
            if (span_log >= BLK_W) begin
                hit = 1'b1;
            end else begin
                lo_blk  = NBLK - (32'd1 << span_log);
                lo_addr = (ADDR_W+1)'(lo_blk) << BLOCK_W;
                hit     = ({1'b0, addr} >= lo_addr);
            end
        end
    end
endmodule

// File: rtl/sfp_cmd_judge.sv
module sfp_cmd_judge
    import sfp_pkg::*;
(
    input  logic          vld,
    input  logic [2:0]    op,
    input  sfp_status_t   st,
    input  logic          wp_n,
    input  logic          prot_hit,
    output sfp_decision_t dec,
    output logic          rd_arm
);
    sfp_op_e op_e;
    logic    busy;
    logic    hw_lock;
    logic    may_write;

    assign op_e      = sfp_op_e'(op);
    assign busy      = st.wip;
    assign hw_lock   = st.srwd && !st.qe && !wp_n;
    assign may_write = !busy && st.wel;

    always_comb begin
        dec    = '0;
        rd_arm = 1'b0;
        if (vld) begin
            unique case (op_e)
                OP_RDSR: begin
                    dec.ok = 1'b1;
                    rd_arm = 1'b1;
                end
                OP_WREN: begin
                    dec.ok      = !busy;
                    dec.set_wel = !busy;
                end
                OP_WRDI: begin
                    dec.ok      = !busy;
                    dec.clr_wel = !busy;
                end
                OP_WRSR: begin
                    dec.ok      = may_write && !hw_lock;
                    dec.load_nv = dec.ok;
                    dec.start   = dec.ok;
                end
                OP_CE: begin
                    dec.ok    = may_write && (st.bp == 4'd0);
                    dec.start = dec.ok;
                end
                default: begin
                    dec.ok    = may_write && !prot_hit && sfp_is_array_op(op_e);
                    dec.start = dec.ok;
                end
            endcase
        end
    end
endmodule

// File: rtl/sfp_status_reg.sv
module sfp_status_reg
    import sfp_pkg::*;
#(
    parameter logic [5:0] INIT_NV = 6'b000000
) (
    input  logic          clk,
    input  logic          rst,
    input  sfp_decision_t dec,
    input  logic [5:0]    nv_wdata,
    input  logic          done_pulse,
    output sfp_status_t   st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= {INIT_NV, 2'b00};
        end else begin
            if (dec.set_wel) st.wel <= 1'b1;
            if (dec.clr_wel) st.wel <= 1'b0;
            if (dec.load_nv) {st.srwd, st.qe, st.bp} <= nv_wdata;
            if (dec.start)   st.wip <= 1'b1;
            if (done_pulse && st.wip) begin
                st.wip <= 1'b0;
                st.wel <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sfp_status_shift.sv
module sfp_status_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         sel_n,
    input  logic         shift,
    input  logic [W-1:0] status,
    output logic         so
);
    localparam int unsigned IDX_W = $clog2(W);

    logic             armed;
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            idx    <= '0;
            shadow <= '0;
            so     <= 1'b0;
        end else if (sel_n) begin
            armed <= 1'b0;
            idx   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            idx   <= '0;
        end else if (armed && shift) begin
            if (idx == '0) begin
                shadow <= status;
                so     <= status[W-1];
            end else begin
                so <= shadow[IDX_W'(W-1) - idx];
            end
            idx <= (idx == IDX_W'(W-1)) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/sfp_status_ctrl.sv
module sfp_status_ctrl
    import sfp_pkg::*;
#(
    parameter int unsigned ADDR_W  = 21,
    parameter int unsigned BLOCK_W = 16,
    parameter logic [5:0]  INIT_NV = 6'b000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_vld,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [5:0]        nv_wdata,
    input  logic              wp_n,
    input  logic              done_pulse,
    input  logic              rd_sel_n,
    input  logic              rd_shift,
    output logic              cmd_ok,
    output logic              cmd_rej,
    output logic [7:0]        status_o,
    output logic              so_bit,
    output logic              sio2_is_data
);
    sfp_status_t   st;
    sfp_decision_t dec;
    logic          prot_hit;
    logic          rd_arm;

    sfp_protect_chk #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_prot (
        .addr (cmd_addr),
        .bp   (st.bp),
        .hit  (prot_hit)
    );

    sfp_cmd_judge u_judge (
        .vld      (cmd_vld),
        .op       (cmd_op),
        .st       (st),
        .wp_n     (wp_n),
        .prot_hit (prot_hit),
        .dec      (dec),
        .rd_arm   (rd_arm)
    );

    sfp_status_reg #(.INIT_NV(INIT_NV)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .nv_wdata   (nv_wdata),
        .done_pulse (done_pulse),
        .st         (st)
    );

    sfp_status_shift #(.W(SFP_STATUS_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .arm    (rd_arm),
        .sel_n  (rd_sel_n),
        .shift  (rd_shift),
        .status (st),
        .so     (so_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_ok  <= 1'b0;
            cmd_rej <= 1'b0;
        end else begin
            cmd_ok  <= cmd_vld && dec.ok;
            cmd_rej <= cmd_vld && !dec.ok;
        end
    end

    assign status_o     = st;
    assign sio2_is_data = st.qe;
endmodule

// File: rtl/sfp_status_ctrl_chk.sv
module sfp_status_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_vld,
    input logic [2:0] cmd_op,
    input logic       wp_n,
    input logic       done_pulse,
    input logic       cmd_ok,
    input logic       cmd_rej,
    input logic [7:0] status_o
);
    p_one_flag_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_ok, cmd_rej}));

    p_resp_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |=> (cmd_ok || cmd_rej));

    p_need_wel_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_op >= 3'd2 && cmd_op <= 3'd6 && !status_o[1]) |=> cmd_rej);

    p_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_op != 3'd7 && status_o[0]) |=> cmd_rej);

    p_rdsr_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_op == 3'd7) |=> cmd_ok);

    p_ce_bp_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_op == 3'd6 && status_o[5:2] != 4'd0) |=> cmd_rej);

    p_hw_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && !status_o[6] && !wp_n) |=> $stable(status_o[7:2]));

    p_rej_keeps_wel_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_rej && !$past(done_pulse)) |-> $stable(status_o[1]));

    p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && status_o[0]) |=> (!status_o[0] && !status_o[1]));
endmodule

bind sfp_status_ctrl sfp_status_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_vld    (cmd_vld),
    .cmd_op     (cmd_op),
    .wp_n       (wp_n),
    .done_pulse (done_pulse),
    .cmd_ok     (cmd_ok),
    .cmd_rej    (cmd_rej),
    .status_o   (status_o)
);

// File: tb/sfp_status_ctrl_test.sv
`timescale 1ns/1ps
module sfp_status_ctrl_test;
    localparam int ADDR_W = 21;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_vld = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [5:0]        nv_wdata = '0;
    logic              wp_n = 1'b1;
    logic              done_pulse = 1'b0;
    logic              rd_sel_n = 1'b1;
    logic              rd_shift = 1'b0;
    logic              cmd_ok, cmd_rej, so_bit, sio2_is_data;
    logic [7:0]        status_o;

    sfp_status_ctrl uut (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .nv_wdata(nv_wdata), .wp_n(wp_n),
        .done_pulse(done_pulse), .rd_sel_n(rd_sel_n), .rd_shift(rd_shift),
        .cmd_ok(cmd_ok), .cmd_rej(cmd_rej), .status_o(status_o),
        .so_bit(so_bit), .sio2_is_data(sio2_is_data)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit summary_done = 1'b0;

    logic [7:0] m_st = 8'h00;
    logic [8:0] q_val[$];
    string      q_req[$];

    localparam logic [2:0] WREN = 3'd0, WRDI = 3'd1, WRSR = 3'd2, PP = 3'd3,
                           SE = 3'd4, BE = 3'd5, CE = 3'd6, RDSR = 3'd7;

    task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && (cmd_ok || cmd_rej)) begin
            if (q_val.size() == 0) begin
                chk(1'b0, "R12 unexpected flag", {30'd0, cmd_ok, cmd_rej}, 32'd0);
            end else begin
                logic [8:0] e;
                string r;
                e = q_val.pop_front();
                r = q_req.pop_front();
                chk({cmd_ok, cmd_rej, status_o} == {e[8], ~e[8], e[7:0]}, r,
                    {22'd0, cmd_ok, cmd_rej, status_o}, {22'd0, e[8], ~e[8], e[7:0]});
            end
        end
    end

    task automatic send(input logic [2:0] op, input logic [ADDR_W-1:0] addr,
                        input logic [7:0] data, input bit exp_ok, input string req);
        @(negedge clk);
        cmd_vld  = 1'b1;
        cmd_op   = op;
        cmd_addr = addr;
        nv_wdata = data[7:2];
        if (exp_ok) begin
            case (op)
                WREN: m_st[1] = 1'b1;
                WRDI: m_st[1] = 1'b0;
                WRSR: begin m_st[7:2] = data[7:2]; m_st[0] = 1'b1; end
                RDSR: ;
                default: m_st[0] = 1'b1;
            endcase
        end
        q_val.push_back({exp_ok, m_st});
        q_req.push_back(req);
        @(negedge clk);
        cmd_vld = 1'b0;
        #1;
        chk(q_val.size() == 0, {req, " R12 no response"}, q_val.size(), 0);
    endtask

    task automatic finish_op(input string req);
        @(negedge clk);
        done_pulse = 1'b1;
        @(negedge clk);
        done_pulse = 1'b0;
        if (m_st[0]) m_st[1:0] = 2'b00;
        chk(status_o == m_st, req, status_o, m_st);
    endtask

    task automatic shift_bits(input int n, inout logic [7:0] acc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_shift = 1'b1;
            @(negedge clk);
            rd_shift = 1'b0;
            acc = {acc[6:0], so_bit};
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end

    initial begin
        logic [7:0] acc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(status_o == 8'h00, "R1 status after reset", status_o, 8'h00);
        chk({cmd_ok, cmd_rej, so_bit, sio2_is_data} == 4'b0, "R1 outputs after reset",
            {cmd_ok, cmd_rej, so_bit, sio2_is_data}, 0);

        send(PP, 21'h0, 8'h00, 1'b0, "R3 program without latch");
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable sets latch");
        send(WRDI, 21'h0, 8'h00, 1'b1, "R5 write disable clears latch");
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(WRSR, 21'h0, 8'h0C, 1'b1, "R2 status write level 3");
        send(WREN, 21'h0, 8'h00, 1'b0, "R6 command while busy");
        send(RDSR, 21'h0, 8'h00, 1'b1, "R10 status read while busy");
        finish_op("R5 done clears busy and latch");
        finish_op("R5 done while idle no change");

        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(PP, 21'h1C0000, 8'h00, 1'b0, "R4 program lowest protected block");
        send(SE, 21'h1FFFFF, 8'h00, 1'b0, "R4 erase top address");
        send(PP, 21'h1BFFFF, 8'h00, 1'b1, "R4 program just below range");
        finish_op("R6 program done");

        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(CE, 21'h0, 8'h00, 1'b0, "R7 chip erase with level 3");
        send(WRSR, 21'h0, 8'h80, 1'b1, "R2 set status-write-disable");
        finish_op("R6 status write done");

        wp_n = 1'b0;
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(WRSR, 21'h0, 8'h00, 1'b0, "R8 hardware protect blocks status write");
        send(PP, 21'h0, 8'h00, 1'b1, "R8 program still allowed");
        finish_op("R6 program done");

        wp_n = 1'b1;
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(WRSR, 21'h0, 8'hC0, 1'b1, "R9 set quad enable");
        finish_op("R9 done");
        chk(sio2_is_data == 1'b1, "R9 pin is data", sio2_is_data, 1);

        wp_n = 1'b0;
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(WRSR, 21'h0, 8'h00, 1'b1, "R9 wp ignored with quad enable");
        finish_op("R9 done");
        chk(sio2_is_data == 1'b0, "R9 pin is write protect", sio2_is_data, 0);
        wp_n = 1'b1;

        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(WRSR, 21'h0, 8'h3C, 1'b1, "R2 level 15");
        finish_op("R6 done");
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(SE, 21'h0, 8'h00, 1'b0, "R4 level 15 protects address 0");
        send(WRSR, 21'h0, 8'h18, 1'b1, "R2 level 6");
        finish_op("R6 done");
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(SE, 21'h0, 8'h00, 1'b0, "R4 level 6 protects all");
        send(WRSR, 21'h0, 8'h04, 1'b1, "R2 level 1");
        finish_op("R6 done");
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(BE, 21'h1F0000, 8'h00, 1'b0, "R4 level 1 top block");
        send(BE, 21'h1EFFFF, 8'h00, 1'b1, "R4 level 1 next block free");
        finish_op("R6 done");

        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(WRSR, 21'h0, 8'h00, 1'b1, "R2 level 0");
        finish_op("R6 done");
        send(WREN, 21'h0, 8'h00, 1'b1, "R5 write enable");
        send(CE, 21'h0, 8'h00, 1'b1, "R7 chip erase with level 0");

        // serial read-out while busy (status 0x03)
        @(negedge clk);
        rd_sel_n = 1'b0;
        send(RDSR, 21'h0, 8'h00, 1'b1, "R10 status read while busy");
        acc = 8'h00;
        shift_bits(8, acc);
        chk(acc == 8'h03, "R10 first byte msb first", acc, 8'h03);
        acc = 8'h00;
        shift_bits(3, acc);
        finish_op("R5 done during read");
        shift_bits(5, acc);
        chk(acc == 8'h03, "R11 byte sampled before done", acc, 8'h03);
        acc = 8'h00;
        shift_bits(8, acc);
        chk(acc == 8'h00, "R11 next byte shows idle", acc, 8'h00);
        acc = 8'hFF;
        shift_bits(8, acc);
        chk(acc == 8'h00, "R10 byte repeats", acc, 8'h00);
        @(negedge clk);
        rd_sel_n = 1'b1;

        chk(q_val.size() == 0, "R12 queue drained", q_val.size(), 0);
        repeat (2) @(negedge clk);
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
        $finish;
    end
endmodule